// File: doc/BRIEF.md
# Row-Hit-First Per-Bank Request Selector

The selector holds pending memory requests for a multi-bank memory controller. Each bank owns a small ordered queue; an incoming request carrying a thread, a bank, a row and a tag is appended to the queue its bank field names. When the command stage asks which request a bank should serve next, the selector returns the oldest queued request that targets the row currently open in that bank. If no such request exists, it returns the oldest request of that bank.

The open row of each bank comes from one of two places. An internal table records the row of every request removed by tag, so the selector follows the rows it has itself sent to the memory. Alternatively, a mode input makes it use per-bank open-row inputs supplied by the surrounding controller. Requests leave either by tag, from any position, with the survivors keeping their order, or through a head-pop that takes the oldest entry regardless of rows. Bad operations raise an error flag and change nothing.

Top module: `rowhit_bank_selector`

## Requirements
- R1: An accepted request (enq_valid high and enq_ready high) joins the tail of the queue of the bank given by enq_bank. enq_ready is low while that bank already holds DEPTH entries, and a request offered then is not stored.
- R2: While query_valid is high and the queried bank holds at least one entry whose row equals the open row of that bank, grant_valid is high and grant_tag is the tag of the oldest such entry, in the same cycle.
- R3: When no entry of the queried bank matches its open row, grant_tag is the tag of the oldest entry of that bank.
- R4: After reset no bank has an open row in the internal table, so the first query of a bank returns its oldest entry.
- R5: A dequeue (deq_valid, deq_bank, deq_tag) removes the oldest entry of that bank whose tag equals deq_tag, at whatever position; the remaining entries keep their relative order.
- R6: With use_ext_rows low, a successful dequeue writes the removed entry's row into the internal table as the open row of its bank, visible from the next cycle.
- R7: With use_ext_rows high, the open row of bank b is ext_open_rows[b*8 +: 8], valid only when ext_open_valid[b] is high, and dequeues leave the internal table unchanged.
- R8: A head-pop (pop_valid, pop_bank) removes the oldest entry of the bank and presents its tag, thread and row on the pop outputs with pop_done high in the same cycle; it does not change the internal open-row table.
- R9: empty is high exactly when every bank queue holds no entries.
- R10: A query of an empty bank, a head-pop of an empty bank, or a dequeue whose tag is not present in the named bank sets err high for the single following cycle and leaves all queues and the open-row table unchanged.
- R11: When deq_valid and pop_valid are high in the same cycle, only the dequeue is performed; pop_done stays low and the pop has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | New request offered |
| enq_ready | output | 1 | Queue of enq_bank has room |
| enq_bank | input | BANK_W (2) | Bank of the new request |
| enq_thread | input | THREAD_W (2) | Thread of the new request |
| enq_row | input | ROW_W (8) | Row of the new request |
| enq_tag | input | TAG_W (4) | Tag identifying the new request |
| query_valid | input | 1 | Ask for the next request of query_bank |
| query_bank | input | BANK_W (2) | Bank being queried |
| grant_valid | output | 1 | A request was found for the query |
| grant_tag | output | TAG_W (4) | Tag of the chosen request |
| grant_thread | output | THREAD_W (2) | Thread of the chosen request |
| grant_row | output | ROW_W (8) | Row of the chosen request |
| deq_valid | input | 1 | Remove the request named by deq_tag |
| deq_bank | input | BANK_W (2) | Bank holding the request to remove |
| deq_tag | input | TAG_W (4) | Tag of the request to remove |
| pop_valid | input | 1 | Remove the oldest request of pop_bank |
| pop_bank | input | BANK_W (2) | Bank to pop |
| pop_done | output | 1 | Head-pop performed this cycle |
| pop_tag | output | TAG_W (4) | Tag of the popped request |
| pop_thread | output | THREAD_W (2) | Thread of the popped request |
| pop_row | output | ROW_W (8) | Row of the popped request |
| use_ext_rows | input | 1 | Take open rows from the external inputs |
| ext_open_valid | input | NUM_BANKS (4) | External open-row valid per bank |
| ext_open_rows | input | NUM_BANKS*ROW_W (32) | External open row per bank, bank b at bits b*8 +: 8 |
| empty | output | 1 | All bank queues are empty |
| err | output | 1 | Previous cycle held an invalid operation |

## Verification
The bench builds the block with its defaults, four banks of eight entries and 8-bit rows. A depth of eight is small enough to fill one bank completely, see enq_ready drop and drain it again head by head, while four banks let one bank sit empty for error checks as others keep distinct open rows and queue contents. The same contents are queried with the internal table and with external rows, so both sources of the open row decide a pick.

// File: rtl/rhsel_pkg.sv
package rhsel_pkg;

    parameter int THREAD_W = 2;
    parameter int ROW_W    = 8;
    parameter int TAG_W    = 4;

    typedef struct packed {
        logic [THREAD_W-1:0] thread;
        logic [ROW_W-1:0]    row;
        logic [TAG_W-1:0]    tag;
    } req_t;

    typedef enum logic [1:0] {
        RM_NONE   = 2'd0,
        RM_BY_TAG = 2'd1,
        RM_HEAD   = 2'd2
    } rm_kind_e;

    function automatic logic row_hit(input req_t ent, input logic open_vld,
                                     input logic [ROW_W-1:0] open_row);
        return open_vld && (ent.row == open_row);
    endfunction

endpackage

// File: rtl/rhsel_bank_queue.sv
module rhsel_bank_queue
    import rhsel_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  req_t             push_ent,
    input  logic             rm,
    input  logic [IDX_W-1:0] rm_idx,
    input  logic             open_vld,
    input  logic [ROW_W-1:0] open_row,
    input  logic [TAG_W-1:0] find_tag,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output req_t             head_ent,
    output req_t             pick_ent,
    output logic             tag_found,
    output logic [IDX_W-1:0] tag_idx,
    output req_t             tag_ent
);

    req_t             slots [DEPTH];
    req_t             nxt   [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;
    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] hit;
    logic [DEPTH-1:0] tmatch;
    logic [IDX_W-1:0] pick_idx;

    // Occupancy, row-hit and tag-match vectors, slot 0 being the oldest
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            live[i]   = CNT_W'(i) < cnt_q;
            hit[i]    = live[i] && row_hit(slots[i], open_vld, open_row);
            tmatch[i] = live[i] && (slots[i].tag == find_tag);
        end
    end

    // Lowest index wins: oldest row hit, otherwise slot 0
    always_comb begin
        pick_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit[i]) pick_idx = IDX_W'(i);
        end
    end

    always_comb begin
        tag_found = 1'b0;
        tag_idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (tmatch[i]) begin
                tag_found = 1'b1;
                tag_idx   = IDX_W'(i);
            end
        end
    end

    assign count    = cnt_q;
    assign full     = (cnt_q == CNT_W'(DEPTH));
    assign head_ent = slots[0];
    assign pick_ent = slots[pick_idx];
    assign tag_ent  = slots[tag_idx];

    // Removal closes the gap by shifting younger entries down; push lands at the tail
    always_comb begin
        for (int i = 0; i < DEPTH; i++) nxt[i] = slots[i];
        cnt_n = cnt_q;
        if (rm) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= rm_idx) nxt[i] = slots[i+1];
            end
            cnt_n = cnt_q - 1'b1;
        end
        if (push) begin
            nxt[cnt_n[IDX_W-1:0]] = push_ent;
            cnt_n = cnt_n + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else begin
            cnt_q <= cnt_n;
            for (int i = 0; i < DEPTH; i++) slots[i] <= nxt[i];
        end
    end

endmodule

// File: rtl/rhsel_open_rows.sv
module rhsel_open_rows
    import rhsel_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       upd,
    input  logic [BANK_W-1:0]          upd_bank,
    input  logic [ROW_W-1:0]           upd_row,
    output logic [NUM_BANKS-1:0]       vld,
    output logic [NUM_BANKS*ROW_W-1:0] rows
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= '0;
            rows <= '0;
        end else if (upd) begin
            vld[upd_bank]                  <= 1'b1;
            rows[upd_bank*ROW_W +: ROW_W]  <= upd_row;
        end
    end

endmodule

// File: rtl/rowhit_bank_selector.sv
module rowhit_bank_selector
    import rhsel_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int DEPTH     = 8,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enq_valid,
    output logic                       enq_ready,
    input  logic [BANK_W-1:0]          enq_bank,
    input  logic [THREAD_W-1:0]        enq_thread,
    input  logic [ROW_W-1:0]           enq_row,
    input  logic [TAG_W-1:0]           enq_tag,
    input  logic                       query_valid,
    input  logic [BANK_W-1:0]          query_bank,
    output logic                       grant_valid,
    output logic [TAG_W-1:0]           grant_tag,
    output logic [THREAD_W-1:0]        grant_thread,
    output logic [ROW_W-1:0]           grant_row,
    input  logic                       deq_valid,
    input  logic [BANK_W-1:0]          deq_bank,
    input  logic [TAG_W-1:0]           deq_tag,
    input  logic                       pop_valid,
    input  logic [BANK_W-1:0]          pop_bank,
    output logic                       pop_done,
    output logic [TAG_W-1:0]           pop_tag,
    output logic [THREAD_W-1:0]        pop_thread,
    output logic [ROW_W-1:0]           pop_row,
    input  logic                       use_ext_rows,
    input  logic [NUM_BANKS-1:0]       ext_open_valid,
    input  logic [NUM_BANKS*ROW_W-1:0] ext_open_rows,
    output logic                       empty,
    output logic                       err
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]           cnt      [NUM_BANKS];
    req_t                       head_e   [NUM_BANKS];
    req_t                       pick_e   [NUM_BANKS];
    req_t                       tag_e    [NUM_BANKS];
    logic [IDX_W-1:0]           tag_idx  [NUM_BANKS];
    logic [IDX_W-1:0]           rm_idx   [NUM_BANKS];
    logic [NUM_BANKS-1:0]       full;
    logic [NUM_BANKS-1:0]       tag_found;
    logic [NUM_BANKS-1:0]       push;
    logic [NUM_BANKS-1:0]       rm;
    logic [NUM_BANKS-1:0]       nonempty;
    logic [NUM_BANKS-1:0]       tbl_vld;
    logic [NUM_BANKS*ROW_W-1:0] tbl_rows;
    logic [NUM_BANKS*CNT_W-1:0] cnt_flat;
    req_t                       new_ent;
    rm_kind_e                   rm_kind;
    logic [BANK_W-1:0]          rm_bank;
    logic                       deq_ok;
    logic [ROW_W-1:0]           upd_row;
    logic                       err_n;

    assign new_ent = '{thread: enq_thread, row: enq_row, tag: enq_tag};

    // Removal arbitration: a dequeue by tag always outranks a head-pop
    always_comb begin
        rm_kind = RM_NONE;
        rm_bank = pop_bank;
        if (deq_valid) begin
            rm_bank = deq_bank;
            if (tag_found[deq_bank]) rm_kind = RM_BY_TAG;
        end else if (pop_valid && nonempty[pop_bank]) begin
            rm_kind = RM_HEAD;
        end
    end

    assign deq_ok  = (rm_kind == RM_BY_TAG);
    assign upd_row = tag_e[deq_bank].row;

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic             bank_open_vld;
            logic [ROW_W-1:0] bank_open_row;

            assign bank_open_vld = use_ext_rows ? ext_open_valid[b] : tbl_vld[b];
            assign bank_open_row = use_ext_rows ? ext_open_rows[b*ROW_W +: ROW_W]
                                                : tbl_rows[b*ROW_W +: ROW_W];
            assign push[b]     = enq_valid && !full[b] && (enq_bank == BANK_W'(b));
            assign rm[b]       = (rm_kind != RM_NONE) && (rm_bank == BANK_W'(b));
            assign rm_idx[b]   = (rm_kind == RM_BY_TAG) ? tag_idx[b] : '0;
            assign nonempty[b] = (cnt[b] != '0);
            assign cnt_flat[b*CNT_W +: CNT_W] = cnt[b];

            rhsel_bank_queue #(.DEPTH(DEPTH)) u_queue (
                .clk       (clk),
                .rst       (rst),
                .push      (push[b]),
                .push_ent  (new_ent),
                .rm        (rm[b]),
                .rm_idx    (rm_idx[b]),
                .open_vld  (bank_open_vld),
                .open_row  (bank_open_row),
                .find_tag  (deq_tag),
                .count     (cnt[b]),
                .full      (full[b]),
                .head_ent  (head_e[b]),
                .pick_ent  (pick_e[b]),
                .tag_found (tag_found[b]),
                .tag_idx   (tag_idx[b]),
                .tag_ent   (tag_e[b])
            );
        end
    endgenerate

    rhsel_open_rows #(.NUM_BANKS(NUM_BANKS)) u_open_rows (
        .clk      (clk),
        .rst      (rst),
        .upd      (deq_ok && !use_ext_rows),
        .upd_bank (deq_bank),
        .upd_row  (upd_row),
        .vld      (tbl_vld),
        .rows     (tbl_rows)
    );

    assign enq_ready    = !full[enq_bank];
    assign grant_valid  = query_valid && nonempty[query_bank];
    assign grant_tag    = pick_e[query_bank].tag;
    assign grant_thread = pick_e[query_bank].thread;
    assign grant_row    = pick_e[query_bank].row;
    assign pop_done     = (rm_kind == RM_HEAD);
    assign pop_tag      = head_e[pop_bank].tag;
    assign pop_thread   = head_e[pop_bank].thread;
    assign pop_row      = head_e[pop_bank].row;
    assign empty        = (nonempty == '0);

    assign err_n = (query_valid && !nonempty[query_bank])
                || (deq_valid && !tag_found[deq_bank])
                || (pop_valid && !deq_valid && !nonempty[pop_bank]);

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= err_n;
    end

endmodule

// File: rtl/rhsel_checker.sv
module rhsel_checker
    import rhsel_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int DEPTH     = 8,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       enq_valid,
    input logic                       enq_ready,
    input logic                       query_valid,
    input logic                       grant_valid,
    input logic                       deq_valid,
    input logic [BANK_W-1:0]          deq_bank,
    input logic                       pop_valid,
    input logic                       pop_done,
    input logic                       use_ext_rows,
    input logic                       empty,
    input logic                       err,
    input logic                       deq_ok,
    input logic [ROW_W-1:0]           upd_row,
    input logic [NUM_BANKS-1:0]       tbl_vld,
    input logic [NUM_BANKS*ROW_W-1:0] tbl_rows,
    input logic [NUM_BANKS*CNT_W-1:0] cnt_flat
);

    assert_enq_fills_R1: assert property (@(posedge clk) disable iff (rst)
        (enq_valid && enq_ready && !deq_valid && !pop_valid) |=> !empty);

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bound
            assert_depth_bound_R1: assert property (@(posedge clk) disable iff (rst)
                cnt_flat[b*CNT_W +: CNT_W] <= CNT_W'(DEPTH));
        end
    endgenerate

    assert_no_open_after_reset_R4: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tbl_vld == '0));

    assert_deq_records_row_R6: assert property (@(posedge clk) disable iff (rst)
        (deq_ok && !use_ext_rows) |=>
        (tbl_vld[$past(deq_bank)] && (tbl_rows[$past(deq_bank)*ROW_W +: ROW_W] == $past(upd_row))));

    assert_ext_table_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        use_ext_rows |=> ($stable(tbl_rows) && $stable(tbl_vld)));

    assert_pop_keeps_rows_R8: assert property (@(posedge clk) disable iff (rst)
        pop_done |=> ($stable(tbl_rows) && $stable(tbl_vld)));

    assert_grant_not_empty_R9: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> !empty);

    assert_empty_query_err_R10: assert property (@(posedge clk) disable iff (rst)
        (query_valid && !grant_valid) |=> err);

    assert_deq_beats_pop_R11: assert property (@(posedge clk) disable iff (rst)
        (deq_valid && pop_valid) |-> !pop_done);

endmodule

bind rowhit_bank_selector rhsel_checker #(.NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH)) u_rhsel_checker (
    .clk          (clk),
    .rst          (rst),
    .enq_valid    (enq_valid),
    .enq_ready    (enq_ready),
    .query_valid  (query_valid),
    .grant_valid  (grant_valid),
    .deq_valid    (deq_valid),
    .deq_bank     (deq_bank),
    .pop_valid    (pop_valid),
    .pop_done     (pop_done),
    .use_ext_rows (use_ext_rows),
    .empty        (empty),
    .err          (err),
    .deq_ok       (deq_ok),
    .upd_row      (upd_row),
    .tbl_vld      (tbl_vld),
    .tbl_rows     (tbl_rows),
    .cnt_flat     (cnt_flat)
);

// File: tb/test_rowhit_bank_selector.sv
module test_rowhit_bank_selector;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OP_ENQ = 2'd0;
    localparam logic [1:0] OP_QRY = 2'd1;
    localparam logic [1:0] OP_DEQ = 2'd2;
    localparam logic [1:0] OP_POP = 2'd3;
    localparam int NVEC = 22;

    // {op, bank, row, tag, expect_ok, expect_tag, requirement}
    localparam logic [24:0] VEC [NVEC] = '{
        {OP_ENQ, 2'd1, 8'h10, 4'd1, 1'b1, 4'd0, 4'd1},  // R1
        {OP_ENQ, 2'd1, 8'h20, 4'd2, 1'b1, 4'd0, 4'd1},  // R1
        {OP_ENQ, 2'd1, 8'h20, 4'd3, 1'b1, 4'd0, 4'd1},  // R1
        {OP_ENQ, 2'd1, 8'h30, 4'd4, 1'b1, 4'd0, 4'd1},  // R1
        {OP_QRY, 2'd1, 8'h00, 4'd0, 1'b1, 4'd1, 4'd4},  // R4 no open row yet
        {OP_DEQ, 2'd1, 8'h00, 4'd3, 1'b1, 4'd0, 4'd5},  // R5 middle entry, opens 0x20
        {OP_QRY, 2'd1, 8'h00, 4'd0, 1'b1, 4'd2, 4'd2},  // R2 hit beats older miss
        {OP_DEQ, 2'd1, 8'h00, 4'd2, 1'b1, 4'd0, 4'd6},  // R6
        {OP_QRY, 2'd1, 8'h00, 4'd0, 1'b1, 4'd1, 4'd3},  // R3 no hit left
        {OP_ENQ, 2'd1, 8'h20, 4'd5, 1'b1, 4'd0, 4'd1},  // R1
        {OP_QRY, 2'd1, 8'h00, 4'd0, 1'b1, 4'd5, 4'd2},  // R2 youngest entry hits
        {OP_POP, 2'd1, 8'h00, 4'd0, 1'b1, 4'd1, 4'd8},  // R8 head ignores hits
        {OP_QRY, 2'd1, 8'h00, 4'd0, 1'b1, 4'd5, 4'd8},  // R8 pop left row at 0x20
        {OP_DEQ, 2'd1, 8'h00, 4'd4, 1'b1, 4'd0, 4'd5},  // R5
        {OP_QRY, 2'd1, 8'h00, 4'd0, 1'b1, 4'd5, 4'd3},  // R3
        {OP_ENQ, 2'd2, 8'h40, 4'd6, 1'b1, 4'd0, 4'd1},  // R1
        {OP_ENQ, 2'd2, 8'h41, 4'd7, 1'b1, 4'd0, 4'd1},  // R1
        {OP_QRY, 2'd2, 8'h00, 4'd0, 1'b1, 4'd6, 4'd4},  // R4 per-bank reset state
        {OP_DEQ, 2'd2, 8'h00, 4'd7, 1'b1, 4'd0, 4'd6},  // R6 opens 0x41 in bank 2
        {OP_ENQ, 2'd2, 8'h41, 4'd8, 1'b1, 4'd0, 4'd1},  // R1
        {OP_QRY, 2'd2, 8'h00, 4'd0, 1'b1, 4'd8, 4'd2},  // R2
        {OP_QRY, 2'd0, 8'h00, 4'd0, 1'b0, 4'd0, 4'd10}  // R10 empty bank
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enq_valid = 1'b0;
    logic        enq_ready;
    logic [1:0]  enq_bank = '0;
    logic [1:0]  enq_thread = '0;
    logic [7:0]  enq_row = '0;
    logic [3:0]  enq_tag = '0;
    logic        query_valid = 1'b0;
    logic [1:0]  query_bank = '0;
    logic        grant_valid;
    logic [3:0]  grant_tag;
    logic [1:0]  grant_thread;
    logic [7:0]  grant_row;
    logic        deq_valid = 1'b0;
    logic [1:0]  deq_bank = '0;
    logic [3:0]  deq_tag = '0;
    logic        pop_valid = 1'b0;
    logic [1:0]  pop_bank = '0;
    logic        pop_done;
    logic [3:0]  pop_tag;
    logic [1:0]  pop_thread;
    logic [7:0]  pop_row;
    logic        use_ext_rows = 1'b0;
    logic [3:0]  ext_open_valid = '0;
    logic [31:0] ext_open_rows = '0;
    logic        empty;
    logic        err;

    int checks = 0;
    int errors = 0;
    logic       s_gv, s_pd, s_rdy, s_err, s_empty;
    logic [3:0] s_gt, s_pt;

    always #(CLK_PERIOD/2) clk = ~clk;

    rowhit_bank_selector i_rowhit_bank_selector (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_bank(enq_bank),
        .enq_thread(enq_thread), .enq_row(enq_row), .enq_tag(enq_tag),
        .query_valid(query_valid), .query_bank(query_bank),
        .grant_valid(grant_valid), .grant_tag(grant_tag),
        .grant_thread(grant_thread), .grant_row(grant_row),
        .deq_valid(deq_valid), .deq_bank(deq_bank), .deq_tag(deq_tag),
        .pop_valid(pop_valid), .pop_bank(pop_bank), .pop_done(pop_done),
        .pop_tag(pop_tag), .pop_thread(pop_thread), .pop_row(pop_row),
        .use_ext_rows(use_ext_rows), .ext_open_valid(ext_open_valid),
        .ext_open_rows(ext_open_rows), .empty(empty), .err(err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Inputs are driven after a falling edge; combinational outputs are
    // sampled 1 time unit later, the registered err just after the rising edge.
    task automatic tick();
        #1;
        s_gv = grant_valid; s_gt = grant_tag;
        s_pd = pop_done;    s_pt = pop_tag;
        s_rdy = enq_ready;
        @(posedge clk);
        #1;
        s_err = err; s_empty = empty;
        enq_valid = 1'b0; query_valid = 1'b0; deq_valid = 1'b0; pop_valid = 1'b0;
    endtask

    task automatic do_enq(input logic [1:0] b, input logic [7:0] r, input logic [3:0] t);
        @(negedge clk);
        enq_valid = 1'b1; enq_bank = b; enq_row = r; enq_tag = t; enq_thread = t[1:0];
        tick();
    endtask

    task automatic do_qry(input logic [1:0] b);
        @(negedge clk);
        query_valid = 1'b1; query_bank = b;
        tick();
    endtask

    task automatic do_deq(input logic [1:0] b, input logic [3:0] t);
        @(negedge clk);
        deq_valid = 1'b1; deq_bank = b; deq_tag = t;
        tick();
    endtask

    task automatic do_pop(input logic [1:0] b);
        @(negedge clk);
        pop_valid = 1'b1; pop_bank = b;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R9 reset state
        chk("R9 empty after reset", int'(empty), 1);
        chk("R1 ready after reset", int'(enq_ready), 1);
        chk("R10 err after reset", int'(err), 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [24:0] v;
            logic [1:0]  op;
            string       tagname;
            v  = VEC[i];
            op = v[24:23];
            tagname = $sformatf("R%0d table[%0d]", v[3:0], i);
            case (op)
                OP_ENQ: do_enq(v[22:21], v[20:13], v[12:9]);
                OP_QRY: do_qry(v[22:21]);
                OP_DEQ: do_deq(v[22:21], v[12:9]);
                default: do_pop(v[22:21]);
            endcase
            case (op)
                OP_ENQ: chk(tagname, int'(s_rdy), 1);
                OP_QRY: begin
                    chk(tagname, int'(s_gv), int'(v[8]));
                    if (v[8]) chk(tagname, int'(s_gt), int'(v[7:4]));
                end
                OP_POP: begin
                    chk(tagname, int'(s_pd), int'(v[8]));
                    if (v[8]) chk(tagname, int'(s_pt), int'(v[7:4]));
                end
                default: ;
            endcase
            chk({tagname, " err"}, int'(s_err), (op != OP_ENQ && !v[8]) ? 1 : 0);
        end
        // State: bank1 {5:0x20} open 0x30; bank2 {6:0x40, 8:0x41} open 0x41

        // R10 unknown tag: error, queue untouched
        do_enq(2'd3, 8'h01, 4'd9);
        do_deq(2'd3, 4'd10);
        chk("R10 err on missing tag", int'(s_err), 1);
        do_qry(2'd3);
        chk("R10 entry kept", int'(s_gt), 9);
        chk("R10 err one cycle", int'(s_err), 0);

        // R7 external open rows
        do_enq(2'd3, 8'h02, 4'd11);
        do_enq(2'd3, 8'h05, 4'd12);
        @(negedge clk);
        use_ext_rows = 1'b1; ext_open_valid = 4'b1000; ext_open_rows = 32'h0200_0000;
        do_qry(2'd3);
        chk("R7 ext row 0x02", int'(s_gt), 11);
        @(negedge clk);
        ext_open_rows = 32'h0100_0000;
        do_qry(2'd3);
        chk("R7 ext row 0x01", int'(s_gt), 9);
        do_deq(2'd3, 4'd12);
        do_enq(2'd3, 8'h05, 4'd13);
        @(negedge clk);
        use_ext_rows = 1'b0; ext_open_valid = '0;
        do_qry(2'd3);
        chk("R7 internal table untouched", int'(s_gt), 9);

        // R11 dequeue and pop together
        @(negedge clk);
        deq_valid = 1'b1; deq_bank = 2'd3; deq_tag = 4'd11;
        pop_valid = 1'b1; pop_bank = 2'd3;
        tick();
        chk("R11 pop_done low", int'(s_pd), 0);
        do_qry(2'd3);
        chk("R11 head not popped", int'(s_gt), 9);

        // R1 fill bank 0, backpressure, tail order
        for (int k = 0; k < 8; k++) do_enq(2'd0, 8'h70 + 8'(k), 4'(k));
        do_enq(2'd0, 8'h7F, 4'd15);
        chk("R1 ready low when full", int'(s_rdy), 0);
        for (int k = 0; k < 8; k++) begin
            do_pop(2'd0);
            chk("R1 R8 fifo order", int'(s_pt), k);
        end
        do_qry(2'd0);
        chk("R1 refused entry absent", int'(s_gv), 0);

        // R5 removal from the middle keeps order
        do_enq(2'd0, 8'h60, 4'd1);
        do_enq(2'd0, 8'h61, 4'd2);
        do_enq(2'd0, 8'h62, 4'd3);
        do_deq(2'd0, 4'd2);
        do_pop(2'd0);
        chk("R5 order after removal", int'(s_pt), 1);
        do_pop(2'd0);
        chk("R5 order after removal", int'(s_pt), 3);

        // R9 drain
        do_pop(2'd1);
        chk("R8 pop bank1", int'(s_pt), 5);
        do_pop(2'd2);
        chk("R8 pop bank2", int'(s_pt), 6);
        do_pop(2'd2);
        do_deq(2'd3, 4'd9);
        chk("R9 not empty", int'(s_empty), 0);
        do_deq(2'd3, 4'd13);
        chk("R9 empty after drain", int'(s_empty), 1);

        // R10 pop of empty bank
        do_pop(2'd2);
        chk("R10 pop_done on empty", int'(s_pd), 0);
        chk("R10 err on empty pop", int'(s_err), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule